// File: doc/BRIEF.md
# Multi-Source Edge Timestamp Capture Queue

This block watches a small set of asynchronous event inputs and records when they happen. Each input is brought into the clock domain by a two-stage synchronizer. An edge detector then looks for either the rising or the falling edge on that input, and software chooses which one for each input. Every input also has its own enable.

Time is split into fixed slots of eight clocks. A free-running 20-bit time base advances once every two clocks. Its upper 18 bits count whole slots and serve as the timestamp.

At the end of every slot in which at least one enabled edge was seen, the block writes one 24-bit entry into an 8-deep queue. The entry holds the timestamp, one flag per input that fired during that slot, and a marker bit that is set when events were lost just before it. Software reads the entry at the head of the queue and pops it with a one-cycle strobe. A ready interrupt stays high while the queue holds data. A sticky loss flag is set when an entry arrives while the queue is full, and it stays set until it is cleared.

Top module: `cap_stamp_fifo`

## Requirements
- R1: After reset the queue is empty, `irq_ready`, `fifo_full` and `ovf_flag` are low, and the time base starts at zero.
- R2: For input i, when `src_pol[i]`=1 only a 0-to-1 transition of `src_in[i]` counts as an event. When `src_pol[i]`=0 only a 1-to-0 transition counts. The opposite transition creates no entry.
- R3: An input whose `src_en[i]` is 0 creates no entry, whatever it does.
- R4: Entry layout: bits [17:0] hold the timestamp, bit 18+i is set when input i fired, and bit 23 is the loss marker. An input change driven in the cycle in which the design's composite count (time base and half-rate phase, cleared by reset and incremented every clock) equals k is stamped with the value (k+2)/8, which is bits [19:2] of the time base.
- R5: Events from several inputs that fall into the same eight-clock slot create exactly one entry, with every one of their flag bits set.
- R6: Events in different slots create separate entries. They are read back in the order they arrived.
- R7: `irq_ready` is high exactly when the queue holds at least one entry. `rd_data` shows the oldest entry, and a `rd_pop` pulse removes it. A `rd_pop` pulse while the queue is empty has no effect.
- R8: The queue holds 8 entries and `fifo_full` is high when it holds 8. An entry that arrives while the queue is full is dropped, and `ovf_flag` is set.
- R9: The first entry accepted after a drop has bit 23 set. Later entries have bit 23 clear until the next drop.
- R10: `ovf_flag` stays high until a one-cycle `ovf_clr` pulse clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 5 | Asynchronous event inputs |
| src_pol | input | 5 | Per-input edge select: 1 selects rising, 0 selects falling |
| src_en | input | 5 | Per-input enable |
| rd_pop | input | 1 | Removes the head entry |
| ovf_clr | input | 1 | Clears the sticky loss flag |
| rd_data | output | 24 | Head entry: marker, input flags, timestamp |
| fifo_full | output | 1 | Queue holds 8 entries |
| irq_ready | output | 1 | Queue is not empty |
| ovf_flag | output | 1 | Sticky flag: an entry was lost |

## Verification
The bench sweeps every input under both edge selects. It checks that the selected edge gets the right flag bit and the timestamp computed from the bench's own cycle count, and that the other edge creates nothing. An off-by-one error in the synchronizer depth or the slot boundary would show up as a timestamp one slot out. Two inputs are made to fire on different cycles of the same slot; a design that cleared its pending flags at the wrong point would produce two entries instead of one. The queue is driven past full, and the bench then checks that the survivors come back in order, that the loss marker appears on exactly one later entry, and that a pop of an empty queue does not corrupt the count.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int N_SRC  = 5;
  localparam int TB_W   = 20;
  localparam int TS_LSB = 2;
  localparam int TS_W   = TB_W - TS_LSB;
  localparam int ENT_W  = TS_W + N_SRC + 1;

  typedef struct packed {
    logic             mark;
    logic [N_SRC-1:0] srcs;
    logic [TS_W-1:0]  ts;
  } cap_entry_t;
endpackage

// File: rtl/cap_edge_det.sv
module cap_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic pol,
  input  logic en,
  output logic hit
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_comb begin
    hit = 1'b0;
    if (en) begin
      if (pol) hit = s2_q & ~s3_q;
      else     hit = ~s2_q & s3_q;
    end
  end

  // R3: a disabled input never reports
  p_no_hit_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !hit);
endmodule

// File: rtl/cap_timebase.sv
module cap_timebase
  import cap_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] ts,
  output logic            slot_end
);
  logic            half_q, half_n;
  logic [TB_W-1:0] tb_q, tb_n;

  always_comb begin
    half_n = ~half_q;
    tb_n   = tb_q;
    if (half_q) tb_n = tb_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      tb_q   <= '0;
    end else begin
      half_q <= half_n;
      tb_q   <= tb_n;
    end
  end

  assign ts       = tb_q[TB_W-1:TS_LSB];
  assign slot_end = half_q & (&tb_q[TS_LSB-1:0]);

  // R4: the time base only ever steps by one
  p_tb_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_q != $past(tb_q)) |-> (tb_q == $past(tb_q) + 1'b1));
  // R4: the timestamp changes only right after a slot end
  p_ts_at_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_end |=> $stable(ts));
endmodule

// File: rtl/cap_fifo.sv
module cap_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop & ~empty;
  assign do_push = push & (~full | do_pop);

  function automatic logic [AW-1:0] inc_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_n  = do_push ? inc_ptr(wp_q) : wp_q;
    rp_n  = do_pop  ? inc_ptr(rp_q) : rp_q;
    cnt_n = cnt_q;
    if (do_push && !do_pop) cnt_n = cnt_q + 1'b1;
    else if (!do_push && do_pop) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= wdata;
  end

  assign rdata = mem_q[rp_q];

  // R8: the occupancy never exceeds the depth
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R7: a pop of an empty queue leaves it empty unless a push arrives
  p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push) |=> empty);
  // R8: a push into a full queue without a pop keeps it full
  p_full_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);
endmodule

// File: rtl/cap_stamp_fifo.sv
module cap_stamp_fifo
  import cap_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_in,
  input  logic [N_SRC-1:0] src_pol,
  input  logic [N_SRC-1:0] src_en,
  input  logic             rd_pop,
  input  logic             ovf_clr,
  output logic [ENT_W-1:0] rd_data,
  output logic             fifo_full,
  output logic             irq_ready,
  output logic             ovf_flag
);
  logic [N_SRC-1:0] hit_vec;
  logic [N_SRC-1:0] pend_q, pend_n, acc;
  logic             mark_q, mark_n, ovf_q, ovf_n;
  logic [TS_W-1:0]  ts;
  logic             slot_end, push_req, accept, drop, empty, pop_eff;
  cap_entry_t       wentry;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    cap_edge_det i_det (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (src_in[i]),
      .pol   (src_pol[i]),
      .en    (src_en[i]),
      .hit   (hit_vec[i])
    );
  end

  cap_timebase i_tb (
    .clk      (clk),
    .rst_n    (rst_n),
    .ts       (ts),
    .slot_end (slot_end)
  );

  assign acc      = pend_q | hit_vec;
  assign push_req = slot_end & (|acc);
  assign pop_eff  = rd_pop & ~empty;
  assign accept   = push_req & (~fifo_full | pop_eff);
  assign drop     = push_req & ~accept;

  always_comb begin
    wentry.mark = mark_q;
    wentry.srcs = acc;
    wentry.ts   = ts;
  end

  always_comb begin
    pend_n = slot_end ? '0 : acc;
    mark_n = mark_q;
    if (drop)        mark_n = 1'b1;
    else if (accept) mark_n = 1'b0;
    ovf_n = ovf_q;
    if (drop)         ovf_n = 1'b1;
    else if (ovf_clr) ovf_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mark_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      pend_q <= pend_n;
      mark_q <= mark_n;
      ovf_q  <= ovf_n;
    end
  end

  cap_fifo #(.DEPTH(DEPTH), .W(ENT_W)) i_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (accept),
    .wdata (wentry),
    .pop   (rd_pop),
    .rdata (rd_data),
    .empty (empty),
    .full  (fifo_full)
  );

  assign irq_ready = ~empty;
  assign ovf_flag  = ovf_q;

  // R8: the loss flag rises only after an entry met a full queue
  p_ovf_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(fifo_full && push_req));
  // R10: the loss flag holds until cleared
  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
  // R9: a drop arms the marker for the next accepted entry
  p_mark_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> mark_q);
  // R7: the ready interrupt follows a push into an empty queue
  p_irq_after_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> irq_ready);
endmodule

// File: tb/test_cap_stamp_fifo.sv
module test_cap_stamp_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  src_in = '0, src_pol = '1, src_en = '1;
  logic        rd_pop = 1'b0, ovf_clr = 1'b0;
  logic [23:0] rd_data;
  logic        fifo_full, irq_ready, ovf_flag;
  int unsigned cyc = 0;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  cap_stamp_fifo i_cap_stamp_fifo (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .src_pol(src_pol),
    .src_en(src_en), .rd_pop(rd_pop), .ovf_clr(ovf_clr), .rd_data(rd_data),
    .fifo_full(fifo_full), .irq_ready(irq_ready), .ovf_flag(ovf_flag)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] ent(bit m, logic [4:0] s, int unsigned c);
    return {m, s, 18'((c + 2) >> 3)};
  endfunction

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pop_check(string req, logic [23:0] exp);
    check(req, {31'd0, irq_ready}, 32'd1);
    check(req, {8'd0, rd_data}, {8'd0, exp});
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  // drive level v on input i, return the cycle of the change
  task automatic drive(int i, bit v, output int unsigned c);
    src_in[i] = v;
    c = cyc;
  endtask

  initial begin
    int unsigned c, c2;
    int unsigned stamps[12];
    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 empty", {31'd0, irq_ready}, 32'd0);
    check("R1 full", {31'd0, fifo_full}, 32'd0);
    check("R1 ovf", {31'd0, ovf_flag}, 32'd0);

    // R2 / R4 sweep over inputs and edge selects
    for (int i = 0; i < 5; i++) begin
      src_pol[i] = 1'b1;
      drive(i, 1'b1, c); wait_n(20);
      pop_check("R2 R4 rising", ent(0, 5'(1 << i), c));
      drive(i, 1'b0, c); wait_n(20);
      check("R2 falling ignored", {31'd0, irq_ready}, 32'd0);
      src_pol[i] = 1'b0;
      drive(i, 1'b1, c); wait_n(20);
      check("R2 rising ignored", {31'd0, irq_ready}, 32'd0);
      drive(i, 1'b0, c); wait_n(20);
      pop_check("R2 R4 falling", ent(0, 5'(1 << i), c));
      src_pol[i] = 1'b1;
    end

    // R3: disabled input
    src_en[2] = 1'b0;
    drive(2, 1'b1, c); wait_n(20);
    drive(2, 1'b0, c); wait_n(20);
    check("R3 disabled", {31'd0, irq_ready}, 32'd0);
    src_en[2] = 1'b1;

    // R5: all inputs at once
    src_in = '1; c = cyc; wait_n(20);
    pop_check("R5 all", ent(0, 5'h1F, c));
    src_in = '0; wait_n(20);
    check("R5 fall ignored", {31'd0, irq_ready}, 32'd0);

    // R5: two inputs on different cycles of one slot
    while (((cyc + 2) % 8) != 0) @(negedge clk);
    drive(0, 1'b1, c); wait_n(3);
    drive(1, 1'b1, c2); wait_n(20);
    pop_check("R5 same slot", ent(0, 5'h03, c));
    check("R5 single entry", {31'd0, irq_ready}, 32'd0);
    src_in = '0; wait_n(20);

    // R7: pop on empty has no effect
    rd_pop = 1'b1; @(negedge clk); rd_pop = 1'b0;
    check("R7 pop empty", {31'd0, irq_ready}, 32'd0);

    // R6 / R8: ten events in separate slots, no reads
    for (int k = 0; k < 10; k++) begin
      drive(3, 1'b1, stamps[k]); wait_n(12);
      drive(3, 1'b0, c); wait_n(12);
    end
    check("R8 full", {31'd0, fifo_full}, 32'd1);
    check("R8 ovf set", {31'd0, ovf_flag}, 32'd1);
    for (int k = 0; k < 8; k++) pop_check("R6 order", ent(0, 5'h08, stamps[k]));
    check("R7 drained", {31'd0, irq_ready}, 32'd0);

    // R9: marker on first entry after loss only
    drive(4, 1'b1, stamps[10]); wait_n(12);
    drive(4, 1'b0, c); wait_n(12);
    drive(4, 1'b1, stamps[11]); wait_n(12);
    drive(4, 1'b0, c); wait_n(12);
    pop_check("R9 marker", ent(1, 5'h10, stamps[10]));
    pop_check("R9 marker cleared", ent(0, 5'h10, stamps[11]));

    // R10: sticky until cleared
    check("R10 still set", {31'd0, ovf_flag}, 32'd1);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    check("R10 cleared", {31'd0, ovf_flag}, 32'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R7 watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule